// File: doc/BRIEF.md
# Serial Receiver with Per-Bit Timing Trim

This block recovers characters from an asynchronous serial line. A programmable divisor produces a sampling tick at sixteen times the nominal bit rate. Each bit of a frame normally spans sixteen ticks. A two-bit trim code for each bit position can stretch that span to seventeen ticks or shrink it to fifteen, so the receiver follows a sender that deliberately lengthens or shortens individual bits. Every data, parity and stop bit is sampled at the middle of its own trimmed span.

A received character goes into a one-entry holding register, and a ready flag marks it as unread. Four sticky error flags go with it: overrun, parity, framing and break. A single read strobe clears the ready flag, the error flags and the timeout indication. When it is enabled, the timeout indication rises after four character times without a new start bit while data is still unread. Bus access and deeper buffering belong to the surrounding logic.

Top module: `uart_rx_trim`

## Requirements
- R1: After reset, `valid_o`, `err_o` and `tout_o` are all zero.
- R2: `len_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data bits arrive least significant first. At frame completion the byte is placed in `data_o` with the unused upper bits zero, and `valid_o` is set.
- R3: `par_i` codes 4, 5, 6 and 7 select odd, even, forced-one and forced-zero parity, and codes 0 to 3 select no parity bit. A parity sample that differs from the expected level sets `err_o[1]`.
- R4: `stop2_i`=1 selects two stop bits and 0 selects one. `err_o[2]` (framing) is set only when the first stop bit samples low.
- R5: Bit index 0 is the start bit, followed by the data bits, the parity bit if present, and then the stop bits. Index k uses trim code `trim_i[2k+1:2k]`: code 1 makes the span 17 ticks, code 3 makes it 15 ticks, and codes 0 and 2 leave it at 16 ticks. The sample is taken at tick span/2 of the bit.
- R6: A sampling tick occurs once every `div_i`+1 clock cycles.
- R7: A low pulse that has ended before the middle of the start bit is ignored. No character is produced.
- R8: `err_o[3]` (break) is set when every data, parity and stop sample is low. The framing flag is then set too, and the stored byte is zero.
- R9: If a frame completes while `valid_o` is set and no read occurs in that cycle, `err_o[0]` (overrun) is set, the new character is discarded, and `data_o` keeps the old byte.
- R10: `rd_i` clears `valid_o`, all of `err_o` and `tout_o` on the next clock edge.
- R11: When `rd_i` coincides with frame completion, the new character is loaded with its own error flags, `valid_o` stays set, and no overrun is flagged.
- R12: With `tout_en_i` set and data unread, `tout_o` rises after 4 × (frame bits) × 16 ticks with no accepted start bit. An accepted start bit or `rd_i` clears it. With `tout_en_i` low it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Tick divisor; one tick per div_i+1 cycles |
| len_i | input | 2 | Data length code (5 + code bits) |
| par_i | input | 3 | Parity mode code |
| stop2_i | input | 1 | Two stop bits when set |
| trim_i | input | 2*FRAME_MAX | Per-bit-index trim codes |
| tout_en_i | input | 1 | Enables the receive timeout |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| rd_i | input | 1 | Read strobe: consumes the held byte and clears the flags |
| data_o | output | 8 | Held received byte |
| valid_o | output | 1 | Unread data present |
| err_o | output | 4 | {break, framing, parity, overrun} |
| tout_o | output | 1 | Receive timeout indication |

## Verification
The read strobe and the completion of a new frame can land on the same clock edge, and the holding register must then favour the incoming character over both the clear and the overrun. The bench first sends two frames without reading and counts the cycles from the start of the second frame until the overrun flag appears, which finds the completion edge. It then repeats the same stimulus with a one-cycle read strobe on exactly that edge. It passes the case only if the new byte is held, `valid_o` is still set and the overrun flag is clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OVS    = 16;
  localparam int SPAN_W = 5;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_BITS  = 2'd1,
    RX_DRAIN = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rx_err_t;

  // tick span of one bit for a given trim code
  function automatic logic [SPAN_W-1:0] span_of(input logic [1:0] code);
    case (code)
      2'd1:    return SPAN_W'(OVS + 1);
      2'd3:    return SPAN_W'(OVS - 1);
      default: return SPAN_W'(OVS);
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int FRAME_MAX = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   rx_i,
  input  logic [1:0]             len_i,
  input  logic [2:0]             par_i,
  input  logic                   stop2_i,
  input  logic [2*FRAME_MAX-1:0] trim_i,
  output logic                   done_o,
  output logic                   start_o,
  output logic [7:0]             data_o,
  output logic                   perr_o,
  output logic                   ferr_o,
  output logic                   brk_o
);
  localparam int IDX_W = $clog2(FRAME_MAX + 1);

  rx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SPAN_W-1:0] cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic              xr_q, xr_d, low_q, low_d;
  logic              perr_q, perr_d, ferr_q, ferr_d;
  logic              done_q, done_d, start_q, start_d;

  logic [IDX_W-1:0]  n_data, par_idx, stop_idx, last_idx;
  logic              has_par, exp_par;
  logic [1:0]        code;
  logic [SPAN_W-1:0] span, half, bit_end;
  logic [2:0]        didx;

  assign n_data   = IDX_W'(len_i) + IDX_W'(5);
  assign has_par  = par_i[2];
  assign par_idx  = n_data + IDX_W'(1);
  assign stop_idx = par_idx + IDX_W'(has_par);
  assign last_idx = stop_idx + IDX_W'(stop2_i);
  assign code     = trim_i[2*int'(idx_q) +: 2];
  assign span     = span_of(code);
  assign half     = span >> 1;
  assign bit_end  = span - SPAN_W'(1);
  assign didx     = idx_q[2:0] - 3'd1;

  always_comb begin
    case (par_i[1:0])
      2'd0:    exp_par = ~xr_q;
      2'd1:    exp_par = xr_q;
      2'd2:    exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q; idx_d = idx_q; cnt_d = cnt_q; sh_d = sh_q;
    xr_d = xr_q; low_d = low_q; perr_d = perr_q; ferr_d = ferr_q;
    done_d = 1'b0; start_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (tick_i && !rx_i) begin
          st_d = RX_BITS; idx_d = '0; cnt_d = SPAN_W'(1); sh_d = '0;
          xr_d = 1'b0; low_d = 1'b1; perr_d = 1'b0; ferr_d = 1'b0;
        end
      end
      RX_BITS: begin
        if (tick_i) begin
          if (cnt_q == bit_end) begin
            cnt_d = '0;
            idx_d = idx_q + IDX_W'(1);
          end else begin
            cnt_d = cnt_q + SPAN_W'(1);
          end
          if (cnt_q == half) begin
            if (idx_q == '0) begin
              if (rx_i) st_d = RX_IDLE;
              else      start_d = 1'b1;
            end else begin
              low_d = low_q & ~rx_i;
              if (idx_q <= n_data) begin
                sh_d[didx] = rx_i;
                xr_d       = xr_q ^ rx_i;
              end else if (has_par && idx_q == par_idx) begin
                perr_d = (rx_i != exp_par);
              end else if (idx_q == stop_idx) begin
                ferr_d = ~rx_i;
              end
              if (idx_q == last_idx) begin
                done_d = 1'b1;
                st_d   = rx_i ? RX_IDLE : RX_DRAIN;
              end
            end
          end
        end
      end
      RX_DRAIN: begin
        if (tick_i && rx_i) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; idx_q <= '0; cnt_q <= '0; sh_q <= '0;
      xr_q <= 1'b0; low_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
      done_q <= 1'b0; start_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; cnt_q <= cnt_d; sh_q <= sh_d;
      xr_q <= xr_d; low_q <= low_d; perr_q <= perr_d; ferr_q <= ferr_d;
      done_q <= done_d; start_q <= start_d;
    end
  end

  assign done_o  = done_q;
  assign start_o = start_q;
  assign data_o  = sh_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign brk_o   = low_q;
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
#(
  parameter int FRAME_MAX  = 12,
  parameter int TOUT_CHARS = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               tick_i,
  input  logic                               done_i,
  input  logic [7:0]                         data_i,
  input  logic                               perr_i,
  input  logic                               ferr_i,
  input  logic                               brk_i,
  input  logic                               start_i,
  input  logic                               rd_i,
  input  logic                               tout_en_i,
  input  logic [$clog2(FRAME_MAX+1)-1:0]     frame_bits_i,
  output logic [7:0]                         data_o,
  output logic                               valid_o,
  output logic [3:0]                         err_o,
  output logic                               tout_o
);
  localparam int TO_MAX = FRAME_MAX * TOUT_CHARS * OVS;
  localparam int TO_W   = $clog2(TO_MAX + 1);

  logic [7:0]      data_q, data_d;
  logic            valid_q, valid_d, tout_q, tout_d;
  rx_err_t         err_q, err_d;
  logic [TO_W-1:0] tcnt_q, tcnt_d, limit;

  assign limit = TO_W'(frame_bits_i) * TO_W'(TOUT_CHARS * OVS);

  always_comb begin
    data_d = data_q; valid_d = valid_q; err_d = err_q;
    tout_d = tout_q; tcnt_d = tcnt_q;
    if (done_i) begin
      if (valid_q && !rd_i) begin
        err_d.ovr = 1'b1;
      end else begin
        data_d  = data_i;
        valid_d = 1'b1;
        err_d   = '{brk: brk_i, frm: ferr_i, par: perr_i, ovr: 1'b0};
      end
    end else if (rd_i) begin
      valid_d = 1'b0;
      err_d   = '0;
    end
    if (rd_i || start_i) tout_d = 1'b0;
    if (!valid_d || !tout_en_i || start_i || done_i || rd_i) begin
      tcnt_d = '0;
    end else if (tick_i && !tout_q) begin
      if (tcnt_q == limit - TO_W'(1)) begin
        tout_d = 1'b1;
        tcnt_d = '0;
      end else begin
        tcnt_d = tcnt_q + TO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; valid_q <= 1'b0; err_q <= '0; tout_q <= 1'b0; tcnt_q <= '0;
    end else begin
      data_q <= data_d; valid_q <= valid_d; err_q <= err_d;
      tout_q <= tout_d; tcnt_q <= tcnt_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign tout_o  = tout_q;
endmodule

// File: rtl/uart_rx_trim.sv
module uart_rx_trim #(
  parameter int DIV_W       = 12,
  parameter int FRAME_MAX   = 12,
  parameter int TOUT_CHARS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIV_W-1:0]       div_i,
  input  logic [1:0]             len_i,
  input  logic [2:0]             par_i,
  input  logic                   stop2_i,
  input  logic [2*FRAME_MAX-1:0] trim_i,
  input  logic                   tout_en_i,
  input  logic                   rxd_i,
  input  logic                   rd_i,
  output logic [7:0]             data_o,
  output logic                   valid_o,
  output logic [3:0]             err_o,
  output logic                   tout_o
);
  localparam int IDX_W = $clog2(FRAME_MAX + 1);

  logic [1:0]       rst_pipe;
  logic             rst_s_n, tick, rx_s;
  logic             frame_done, frame_start, f_perr, f_ferr, f_brk;
  logic [7:0]       f_data;
  logic [IDX_W-1:0] frame_bits;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // start + data + parity + stops
  assign frame_bits = IDX_W'(7) + IDX_W'(len_i) + IDX_W'(par_i[2]) + IDX_W'(stop2_i);

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .div_i(div_i), .tick_o(tick)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d_i(rxd_i), .q_o(rx_s)
  );

  uart_rx_frame #(.FRAME_MAX(FRAME_MAX)) u_frame (
    .clk(clk), .rst_n(rst_s_n), .tick_i(tick), .rx_i(rx_s),
    .len_i(len_i), .par_i(par_i), .stop2_i(stop2_i), .trim_i(trim_i),
    .done_o(frame_done), .start_o(frame_start), .data_o(f_data),
    .perr_o(f_perr), .ferr_o(f_ferr), .brk_o(f_brk)
  );

  uart_rx_hold #(.FRAME_MAX(FRAME_MAX), .TOUT_CHARS(TOUT_CHARS)) u_hold (
    .clk(clk), .rst_n(rst_s_n), .tick_i(tick), .done_i(frame_done),
    .data_i(f_data), .perr_i(f_perr), .ferr_i(f_ferr), .brk_i(f_brk),
    .start_i(frame_start), .rd_i(rd_i), .tout_en_i(tout_en_i),
    .frame_bits_i(frame_bits), .data_o(data_o), .valid_o(valid_o),
    .err_o(err_o), .tout_o(tout_o)
  );
endmodule

// File: rtl/uart_rx_trim_chk.sv
module uart_rx_trim_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic       done,
  input logic       valid,
  input logic [3:0] err,
  input logic [7:0] data,
  input logic       tout
);
  // R10: error flags only exist alongside held data
  p_err_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err != 4'd0) |-> valid);

  // R10: a read without a completing frame empties everything
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> (!valid && err == 4'd0 && !tout));

  // R9: completion onto unread data keeps the old byte and flags overrun
  p_overrun_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd && done) |=> (err[0] && $stable(data)));

  // R11: a read at completion loads the new byte without overrun
  p_coincide_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && done) |=> (valid && !err[0]));

  // R8: break always comes with a framing error
  p_break_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err[3] |-> err[2]);

  // R12: timeout only while data is held
  p_tout_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tout |-> valid);

  // R2: data becomes ready only from a completed frame
  p_load_from_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(done));
endmodule

bind uart_rx_trim uart_rx_trim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd_i), .done(frame_done),
  .valid(valid_o), .err(err_o), .data(data_o), .tout(tout_o)
);

// File: tb/sim_uart_rx_trim.sv
module sim_uart_rx_trim;
  logic        clk = 1'b0;
  logic        rst_n, stop2, tout_en, rxd, rd;
  logic [11:0] div;
  logic [1:0]  len;
  logic [2:0]  par;
  logic [23:0] trim;
  logic [7:0]  data_o;
  logic        valid_o, tout_o;
  logic [3:0]  err_o;
  int          n_run = 0, n_fail = 0;
  bit          ended = 0;

  always #5 clk = ~clk;

  uart_rx_trim u0 (
    .clk(clk), .rst_n(rst_n), .div_i(div), .len_i(len), .par_i(par),
    .stop2_i(stop2), .trim_i(trim), .tout_en_i(tout_en), .rxd_i(rxd),
    .rd_i(rd), .data_o(data_o), .valid_o(valid_o), .err_o(err_o), .tout_o(tout_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int span(input logic [1:0] c);
    return (c == 2'd1) ? 17 : (c == 2'd3) ? 15 : 16;
  endfunction

  function automatic logic [7:0] mask_of();
    return 8'((1 << (5 + len)) - 1);
  endfunction

  function automatic logic par_level(input logic [7:0] d, input bit bad);
    logic [7:0] m;
    logic p;
    m = d & mask_of();
    case (par)
      3'd4:    p = ~^m;
      3'd5:    p = ^m;
      3'd6:    p = 1'b1;
      default: p = 1'b0;
    endcase
    return p ^ bad;
  endfunction

  // expected {break, framing, parity, overrun}
  function automatic logic [3:0] exp_err(input logic [7:0] d, input bit bad,
                                         input bit low1, input bit low2);
    logic hp, brk;
    hp  = par[2];
    brk = ((d & mask_of()) == 8'd0) && (!hp || !par_level(d, bad)) && low1 && (!stop2 || low2);
    return {brk, low1, hp && bad, 1'b0};
  endfunction

  task automatic send_bit(input logic lvl, input int idx);
    rxd = lvl;
    repeat (span(trim[2*idx +: 2]) * (int'(div) + 1)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad, input bit low1, input bit low2);
    int idx = 0;
    send_bit(1'b0, idx); idx++;
    for (int i = 0; i < 5 + int'(len); i++) begin send_bit(d[i], idx); idx++; end
    if (par[2]) begin send_bit(par_level(d, bad), idx); idx++; end
    send_bit(!low1, idx); idx++;
    if (stop2) begin send_bit(!low2, idx); idx++; end
    rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
  endtask

  task automatic frame_check(input logic [7:0] d, input bit bad, input bit low1,
                             input bit low2, input string req);
    send_frame(d, bad, low1, low2);
    chk(valid_o == 1'b1, {req, " valid"}, valid_o, 1);
    chk(data_o == (d & mask_of()), {req, " data"}, data_o, d & mask_of());
    chk(err_o == exp_err(d, bad, low1, low2), {req, " err"}, err_o, exp_err(d, bad, low1, low2));
    do_read();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int k;
    void'($urandom(32'd7));
    rst_n = 1'b0; rxd = 1'b1; rd = 1'b0; div = '0; len = 2'd3; par = 3'd0;
    stop2 = 1'b0; trim = '0; tout_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(valid_o == 0 && err_o == 0 && tout_o == 0, "R1 reset outputs", {valid_o, err_o, tout_o}, 0);

    frame_check(8'hA5, 0, 0, 0, "R2 8-bit frame");
    chk(valid_o == 0 && err_o == 0, "R10 read clears", {valid_o, err_o}, 0);
    len = 2'd0; frame_check(8'hFF, 0, 0, 0, "R2 5-bit frame");
    len = 2'd2; frame_check(8'hD6, 0, 0, 0, "R2 7-bit frame");
    len = 2'd3;

    for (int p = 4; p < 8; p++) begin
      par = 3'(p);
      frame_check(8'h6B, 0, 0, 0, "R3 parity good");
      frame_check(8'h6B, 1, 0, 0, "R3 parity bad");
    end
    par = 3'd0;

    stop2 = 1'b1;
    frame_check(8'h3C, 0, 1, 0, "R4 first stop low");
    frame_check(8'h3C, 0, 0, 1, "R4 second stop low ignored");
    stop2 = 1'b0;

    trim = 24'h555555; frame_check(8'h3C, 0, 0, 0, "R5 stretched bits");
    trim = 24'hFFFFFF; frame_check(8'hC3, 0, 0, 0, "R5 shrunk bits");
    trim = 24'hAAAAAA; frame_check(8'h81, 0, 0, 0, "R5 code 2 no effect");
    trim = 24'h0; div = 12'd3;
    frame_check(8'h4E, 0, 0, 0, "R6 divisor 3");
    div = 12'd0;

    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    chk(valid_o == 0, "R7 glitch ignored", valid_o, 0);
    frame_check(8'h99, 0, 0, 0, "R7 recovery frame");

    frame_check(8'h00, 0, 1, 1, "R8 break");

    send_frame(8'h11, 0, 0, 0);
    send_frame(8'h22, 0, 0, 0);
    chk(data_o == 8'h11, "R9 overrun keeps old", data_o, 8'h11);
    chk(err_o == 4'b0001, "R9 overrun flag", err_o, 1);
    do_read();
    chk(valid_o == 0 && err_o == 0, "R10 clear after overrun", {valid_o, err_o}, 0);

    // calibrate completion edge, then read exactly there
    send_frame(8'h11, 0, 0, 0);
    k = 0;
    fork
      send_frame(8'h22, 0, 0, 0);
      begin while (!err_o[0]) begin @(negedge clk); k++; end end
    join
    do_read();
    send_frame(8'h11, 0, 0, 0);
    fork
      send_frame(8'h33, 0, 0, 0);
      begin
        repeat (k - 1) @(negedge clk);
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        chk(valid_o == 1 && data_o == 8'h33 && err_o == 0, "R11 read at completion",
            {valid_o, data_o, err_o}, {1'b1, 8'h33, 4'h0});
      end
    join
    do_read();

    tout_en = 1'b1;
    send_frame(8'h5A, 0, 0, 0);
    repeat (560) @(negedge clk);
    chk(tout_o == 0, "R12 before limit", tout_o, 0);
    repeat (140) @(negedge clk);
    chk(tout_o == 1, "R12 after limit", tout_o, 1);
    send_frame(8'h77, 0, 0, 0);
    chk(tout_o == 0 && err_o[0] == 1, "R12 start clears", {tout_o, err_o[0]}, 2'b01);
    repeat (700) @(negedge clk);
    do_read();
    chk(tout_o == 0, "R12 read clears", tout_o, 0);
    tout_en = 1'b0;
    send_frame(8'h5A, 0, 0, 0);
    repeat (900) @(negedge clk);
    chk(tout_o == 0, "R12 disabled", tout_o, 0);
    do_read();

    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      bit bad, l1, l2;
      int pc;
      div   = 12'($urandom_range(0, 3));
      len   = 2'($urandom_range(0, 3));
      pc    = $urandom_range(0, 4);
      par   = (pc == 0) ? 3'd0 : 3'(pc + 3);
      stop2 = 1'($urandom_range(0, 1));
      trim  = 24'($urandom);
      d     = 8'($urandom);
      bad   = par[2] && ($urandom_range(0, 4) == 0);
      l1    = ($urandom_range(0, 5) == 0);
      l2    = stop2 && ($urandom_range(0, 5) == 0);
      frame_check(d, bad, l1, l2, "R5 random frame");
    end

    finish_run();
  end
endmodule